// File: doc/BRIEF.md
# Flash Programming Mode Controller

This block is the device-side logic that lets an external programmer load, clear and inspect an on-chip code store. The programmer presents an address, a data byte and a four-bit control code, holds the program-enable level high, and pulses an active-low strobe. A byte write or a lock-bit write then runs on its own timer, and the ready output stays low while it runs. A read of the byte being written returns that byte with bit 7 inverted until the write finishes.

Cells can only be cleared from one to zero. A byte that already holds data gets fresh contents only after a whole-array erase. The erase is armed by holding the strobe low for a minimum number of clocks. Two lock bits stop verify reads from returning stored data. The fixed identification bytes stay readable whatever the lock state.

The data bus is split into an input, an output and an output enable, so that a tri-state pad can be placed at the chip boundary.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset every byte reads FFH, both lock bits are clear, rdy is 1 and data_oe is 0 unless a read mode is selected.
- R2: ctl[1:0]=01 selects byte write. A falling edge of prog_n with pgm_en=1 and rdy=1 latches addr and data_i. The stored byte becomes old AND data_i once the write finishes.
- R3: rdy goes low in the cycle after the clock edge that sees the strobe fall, and stays low for exactly WRITE_CYC cycles.
- R4: ctl=4'b1100 is verify. While a write is running, a verify of its address returns the new byte with bit 7 inverted. After rdy returns high, the true byte is returned.
- R5: ctl[1:0]=10 selects chip erase. Holding prog_n low with pgm_en=1 for ERASE_CYC consecutive clock edges sets every byte to FFH and clears both lock bits. A shorter hold changes nothing.
- R6: A strobe has no effect while pgm_en=0 or while rdy=0.
- R7: Verify drives data_oe=1 with the stored byte only while both lock bits are clear. With any lock bit set, data_oe is 0.
- R8: ctl=4'b0000 is the signature read, which the locks do not gate. It returns 1EH at 030H, 51H at 031H, and at 032H it returns FFH when HV_PART=1 or 05H when HV_PART=0. All other addresses return FFH.
- R9: data_oe is 0 whenever ctl[1:0] is not 00, and also when ctl[1:0]=00 with ctl[3:2] equal to 01 or 10.
- R10: ctl[1:0]=11 is a lock write. It is self-timed like a byte write and sets the lock bits selected by ctl[2] (first bit) and ctl[3] (second bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Byte address |
| data_i | input | 8 | Data from programmer |
| data_o | output | 8 | Read data toward the pad |
| data_oe | output | 1 | Pad output enable |
| ctl | input | 4 | Mode code {aux[1:0], op[1:0]} |
| prog_n | input | 1 | Active-low program strobe |
| pgm_en | input | 1 | Program-enable level |
| rdy | output | 1 | High when ready, low while busy |

## Verification
A stuck or miscounted write timer shows up at rdy: the number of low cycles differs from WRITE_CYC on the very first write. The polled byte also keeps its inverted bit 7 for too long or too short a time. A byte committed at the wrong moment, or committed without the AND rule, appears at the next verify of that address. A lock bit that was never set, or one that survives an erase, shows up as a wrong data_oe on the first verify after the lock write or after the erase.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int AW        = 8,
  parameter int WRITE_CYC = 20,
  parameter int ERASE_CYC = 50,
  parameter bit HV_PART   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data_i,
  output logic [7:0]    data_o,
  output logic          data_oe,
  input  logic [3:0]    ctl,
  input  logic          prog_n,
  input  logic          pgm_en,
  output logic          rdy
);
  localparam int DEPTH = 1 << AW;
  localparam int WCW   = $clog2(WRITE_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);
  localparam logic [1:0] OP_RD = 2'b00, OP_WR = 2'b01, OP_ER = 2'b10, OP_LK = 2'b11;

  logic [7:0]    mem [DEPTH];
  logic          busy, prog_q, wlock;
  logic [WCW-1:0] wcnt;
  logic [ECW-1:0] ecnt;
  logic [AW-1:0] wa;
  logic [7:0]    wv;
  logic [1:0]    wlk, lock;

  wire [1:0] op  = ctl[1:0];
  wire [1:0] aux = ctl[3:2];
  wire start    = prog_q & ~prog_n & pgm_en & ~busy & (op == OP_WR || op == OP_LK);
  wire erase_on = ~busy & pgm_en & ~prog_n & (op == OP_ER);
  wire erase_go = erase_on & (ecnt == ECW'(ERASE_CYC - 1));

  assign rdy = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      busy   <= 1'b0;
      prog_q <= 1'b1;
      wlock  <= 1'b0;
      wcnt   <= '0;
      ecnt   <= '0;
      wa     <= '0;
      wv     <= 8'hFF;
      wlk    <= 2'b00;
      lock   <= 2'b00;
    end else begin
      prog_q <= prog_n;
      if (erase_on) begin
        if (ecnt != ECW'(ERASE_CYC)) ecnt <= ecnt + 1'b1;
      end else begin
        ecnt <= '0;
      end
      if (erase_go) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        lock <= 2'b00;
      end
      if (start) begin
        busy  <= 1'b1;
        wcnt  <= WCW'(WRITE_CYC - 1);
        wa    <= addr;
        wv    <= mem[addr] & data_i;
        wlock <= (op == OP_LK);
        wlk   <= aux;
      end else if (busy) begin
        if (wcnt == '0) begin
          busy <= 1'b0;
          if (wlock) lock <= lock | wlk;
          else       mem[wa] <= wv;
        end else begin
          wcnt <= wcnt - 1'b1;
        end
      end
    end
  end

  logic [7:0] sig;
  always_comb begin
    sig = 8'hFF;
    if (addr == AW'(8'h30)) sig = 8'h1E;
    else if (addr == AW'(8'h31)) sig = 8'h51;
    else if (addr == AW'(8'h32)) sig = HV_PART ? 8'hFF : 8'h05;
  end

  always_comb begin
    data_oe = 1'b0;
    data_o  = 8'h00;
    if (op == OP_RD) begin
      if (aux == 2'b11 && lock == 2'b00) begin
        data_oe = 1'b1;
        data_o  = (busy && !wlock && addr == wa) ? {~wv[7], wv[6:0]} : mem[addr];
      end else if (aux == 2'b00) begin
        data_oe = 1'b1;
        data_o  = sig;
      end
    end
  end
endmodule

module flash_prog_ctrl_sva #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [3:0]    ctl,
  input logic          prog_n,
  input logic          pgm_en,
  input logic          rdy,
  input logic          data_oe,
  input logic [7:0]    data_o,
  input logic [1:0]    lock,
  input logic [AW-1:0] wa
);
  a_r3_busy_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prog_n) && ctl[1:0] == 2'b01 && pgm_en && rdy) |=> !rdy);

  a_r6_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |=> $stable(wa));

  a_r7_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != 2'b00 && ctl == 4'b1100) |-> !data_oe);

  a_r9_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (ctl[1:0] == 2'b00 && (ctl[3:2] == 2'b11 || ctl[3:2] == 2'b00)));

  a_r8_sig_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 4'b0000 && addr == AW'(8'h30)) |-> (data_oe && data_o == 8'h1E));
endmodule

bind flash_prog_ctrl flash_prog_ctrl_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl), .prog_n(prog_n),
  .pgm_en(pgm_en), .rdy(rdy), .data_oe(data_oe), .data_o(data_o),
  .lock(lock), .wa(wa)
);

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;
  localparam int AW = 8, WC = 20, EC = 50;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data_i = 8'h00, data_o;
  logic data_oe, rdy;
  logic [3:0] ctl = 4'b1100;
  logic prog_n = 1'b1, pgm_en = 1'b1;
  int checks = 0, errors = 0;

  flash_prog_ctrl #(.AW(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .HV_PART(1'b1)) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .ctl(ctl), .prog_n(prog_n), .pgm_en(pgm_en), .rdy(rdy));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] c, input logic [7:0] a, output logic [8:0] v);
    @(negedge clk); ctl = c; addr = a; #1; v = {data_oe, data_o};
  endtask

  task automatic strobe_op(input logic [3:0] c, input logic [7:0] a, input logic [7:0] d, output int n);
    @(negedge clk); ctl = c; addr = a; data_i = d; prog_n = 1'b1;
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    n = 0;
    while (!rdy) begin n++; @(negedge clk); end
  endtask

  // {kind, addr, data, expected}: kind 0 write, 1 verify, 2 signature
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h10, 8'hA5, 8'h00}, {2'd1, 8'h10, 8'h00, 8'hA5},
    {2'd0, 8'h11, 8'h3C, 8'h00}, {2'd1, 8'h11, 8'h00, 8'h3C},
    {2'd0, 8'h10, 8'hF0, 8'h00}, {2'd1, 8'h10, 8'h00, 8'hA0},
    {2'd1, 8'h12, 8'h00, 8'hFF}, {2'd2, 8'h30, 8'h00, 8'h1E},
    {2'd2, 8'h31, 8'h00, 8'h51}, {2'd2, 8'h32, 8'h00, 8'hFF},
    {2'd2, 8'h77, 8'h00, 8'hFF}, {2'd1, 8'h00, 8'h00, 8'hFF}
  };

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    logic [8:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1; chk("R1 rdy", {8'h00, rdy}, 9'h001);
    rd(4'b1100, 8'h45, v); chk("R1 blank", v, {1'b1, 8'hFF});
    rd(4'b0001, 8'h45, v); chk("R1 oe off", {v[8], 8'h00}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][25:24])
        2'd0: begin
          strobe_op(4'b0001, VEC[i][23:16], VEC[i][15:8], n);
          chk("R3 busy length", 9'(n), 9'(WC));
        end
        2'd1: begin rd(4'b1100, VEC[i][23:16], v); chk("R2 verify", v, {1'b1, VEC[i][7:0]}); end
        default: begin rd(4'b0000, VEC[i][23:16], v); chk("R8 signature", v, {1'b1, VEC[i][7:0]}); end
      endcase
    end

    // R4 polling: write 5A to 0x40, read during busy
    @(negedge clk); ctl = 4'b0001; addr = 8'h40; data_i = 8'h5A;
    @(negedge clk); prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1; ctl = 4'b1100; #1;
    chk("R3 rdy low", {8'h00, rdy}, 9'h000);
    chk("R4 poll", {data_oe, data_o}, {1'b1, 8'hDA});
    // R6 strobe while busy targets 0x41
    @(negedge clk); ctl = 4'b0001; addr = 8'h41; data_i = 8'h00; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1; ctl = 4'b1100; addr = 8'h40;
    while (!rdy) @(negedge clk);
    rd(4'b1100, 8'h40, v); chk("R4 true data", v, {1'b1, 8'h5A});
    rd(4'b1100, 8'h41, v); chk("R6 busy strobe ignored", v, {1'b1, 8'hFF});

    // R6 pgm_en low
    pgm_en = 1'b0;
    strobe_op(4'b0001, 8'h42, 8'h00, n);
    chk("R6 no enable busy", 9'(n), 9'd0);
    rd(4'b1100, 8'h42, v); chk("R6 no enable data", v, {1'b1, 8'hFF});
    pgm_en = 1'b1;

    // R9 oe off for other modes
    rd(4'b0010, 8'h40, v); chk("R9 erase mode", {v[8], 8'h00}, 9'h000);
    rd(4'b0100, 8'h40, v); chk("R9 read aux 01", {v[8], 8'h00}, 9'h000);

    // R5 short hold does nothing
    @(negedge clk); ctl = 4'b0010; prog_n = 1'b0;
    repeat (EC - 2) @(negedge clk);
    prog_n = 1'b1;
    rd(4'b1100, 8'h40, v); chk("R5 short hold", v, {1'b1, 8'h5A});

    // R10 lock write, R7 gating, R8 unaffected
    strobe_op(4'b0111, 8'h00, 8'h00, n);
    chk("R10 lock busy", 9'(n), 9'(WC));
    rd(4'b1100, 8'h40, v); chk("R7 locked", {v[8], 8'h00}, 9'h000);
    rd(4'b0000, 8'h31, v); chk("R8 sig when locked", v, {1'b1, 8'h51});

    // R5 full erase clears data and locks
    @(negedge clk); ctl = 4'b0010; prog_n = 1'b0;
    repeat (EC + 2) @(negedge clk);
    prog_n = 1'b1;
    rd(4'b1100, 8'h40, v); chk("R5 erased", v, {1'b1, 8'hFF});
    rd(4'b1100, 8'h10, v); chk("R5 erased 2", v, {1'b1, 8'hFF});

    // R2 rewrite after erase, R10 second lock bit
    strobe_op(4'b0001, 8'h10, 8'h0F, n);
    rd(4'b1100, 8'h10, v); chk("R2 after erase", v, {1'b1, 8'h0F});
    strobe_op(4'b1011, 8'h00, 8'h00, n);
    rd(4'b1100, 8'h10, v); chk("R10 second lock", {v[8], 8'h00}, 9'h000);

    finish_up();
  end
endmodule